// File: doc/BRIEF.md
# STN Panel Refresh Controller

This block keeps a single-scan monochrome STN panel refreshed from a packed frame buffer in memory. An address generator reads 32-bit words through a simple request/acknowledge read port, starting at a programmable base address. The words pass through a small prefetch FIFO to an unpacker, which cuts out four pixels per transfer. Each pixel is reduced to one on/off bit, and the four bits go onto a 4-bit data bus together with a one-cycle pixel strobe.

A timing generator counts transfers within a line, inserts a fixed blanking gap after each line, and issues a line pulse and a frame pulse. It also drives an AC-bias output that flips every frame. Gray levels at 2 and 4 bits per pixel become on/off patterns by frame-rate modulation: the pixel value is compared against a free-running frame counter.

The controller is enabled by a single level. Clearing it stops all output, empties the prefetch path and rewinds the address and frame counters.

Top module: `stn_refresh`

## Requirements
- R1: After reset, and while `enable_i` is low, `dd_o`, `pclk_o`, `lclk_o`, `frm_o` and `underrun_o` are 0 and `mem_req_o` is low.
- R2: Within a frame, successive acknowledged reads use byte addresses `base_addr_i + 4*k`. The index k starts at 0 and returns to 0 after `fb_words_i` words (1 to 32768, i.e. up to 128 KB).
- R3: A line carries exactly `4*(width_i+1)` transfers, for 32 to 1024 pixels in 16-pixel steps with `width_i` from 1 to 63. Within a line, consecutive `pclk_o` strobes are exactly DIV cycles apart, and each strobe lasts one cycle.
- R4: Pixels sit LSB-first in each word, and `dd_o[0]` carries the earliest pixel of a transfer. `bpp_i` = 0, 1 or 2 selects 1, 2 or 4 bits per pixel, so a word holds 32, 16 or 8 pixels. The pixel stream runs across line ends without realignment.
- R5: A pixel with value v is driven as follows: at 1 bpp the bit is v. At 2 bpp it is 1 when v > fc[1:0]. At 4 bpp it is 1 when v > fc. Here fc is a 4-bit count of frames completed since enable.
- R6: `lclk_o` is a one-cycle pulse that follows the last transfer of each line. The first `pclk_o` of the next line comes HBLANK+1 cycles after that pulse.
- R7: `frm_o` is high only together with the `lclk_o` of the first line (line 0) of a frame.
- R8: `acb_o` inverts in the cycle `frm_o` is high and holds otherwise.
- R9: After the line numbered `lines_i-1`, the next frame starts again from `base_addr_i`, and fc increments.
- R10: A transfer that finds no pixel data drives `dd_o` = 0 and sets `underrun_o`. The flag stays set until `enable_i` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run level; low flushes and rewinds |
| base_addr_i | input | AW | Frame buffer base byte address (word aligned) |
| width_i | input | 6 | Panel width in 16-pixel units minus one (1..63) |
| bpp_i | input | 2 | 0: 1 bpp, 1: 2 bpp, 2: 4 bpp |
| lines_i | input | LW | Lines per frame (>= 1) |
| fb_words_i | input | FBW | Frame buffer size in 32-bit words (1..32768) |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | AW | Read byte address |
| mem_ack_i | input | 1 | Read acknowledge, data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |
| dd_o | output | 4 | Display data, four pixels per transfer |
| pclk_o | output | 1 | Transfer strobe |
| lclk_o | output | 1 | Line pulse |
| frm_o | output | 1 | Frame pulse |
| acb_o | output | 1 | AC-bias drive |
| underrun_o | output | 1 | Sticky data-underrun flag |

## Verification
The bench aims at widths where a line ends partway through a word at 1 bpp. A design that realigned to a word boundary at each line end would shift every later pixel. It also uses buffer sizes of a single word and sizes smaller than a frame, so that an address generator that wrapped one word late, or wrapped to zero instead of the base, would fetch wrong data. Multi-frame runs at 2 and 4 bpp show whether the frame counter advances at the right point, since a counter one frame early or late flips gray pixels. A forced memory stall checks that starved transfers go out as zero and that the underrun flag stays set until the block is disabled.

// File: rtl/stn_pkg.sv
package stn_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    BSEL_1 = 2'd0,
    BSEL_2 = 2'd1,
    BSEL_4 = 2'd2
  } bsel_e;

  function automatic bsel_e decode_bpp(input logic [1:0] code);
    if (code[1])      return BSEL_4;
    else if (code[0]) return BSEL_2;
    else              return BSEL_1;
  endfunction
endpackage

// File: rtl/stn_fetch.sv
module stn_fetch #(
  parameter int unsigned AW    = 32,
  parameter int unsigned FBW   = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [AW-1:0] base_i,
  input  logic [FBW-1:0] fb_words_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  input  logic          pop_i,
  output logic [31:0]   head_o,
  output logic          empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [31:0]    fifo_q [DEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  count;
  logic [FBW-1:0] wcnt;
  logic           push, pop, full;

  assign full       = (count == CW'(DEPTH));
  assign empty_o    = (count == '0);
  assign mem_req_o  = !flush_i && !full;
  assign mem_addr_o = base_i + (AW'(wcnt) << 2);
  assign head_o     = fifo_q[rd_ptr];
  assign push       = mem_req_o && mem_ack_i;
  assign pop        = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      wcnt   <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      wcnt   <= '0;
    end else begin
      if (push) begin
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        wcnt   <= (wcnt == fb_words_i - 1'b1) ? '0 : wcnt + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) fifo_q[wr_ptr] <= mem_rdata_i;
  end
endmodule

// File: rtl/stn_unpack.sv
module stn_unpack
  import stn_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic        xfer_i,
  input  logic [1:0]  bpp_i,
  input  logic [3:0]  fc_i,
  input  logic [31:0] head_i,
  input  logic        empty_i,
  output logic        pop_o,
  output logic        ok_o,
  output logic [3:0]  pix_o
);
  bsel_e       bsel;
  logic [31:0] cur, word, shifted;
  logic [3:0]  left, per_m1;
  logic [4:0]  step;
  logic        have;

  assign bsel    = decode_bpp(bpp_i);
  assign step    = 5'd4 << bsel;
  assign per_m1  = 4'd7 >> bsel;
  assign ok_o    = have || !empty_i;
  assign word    = have ? cur : head_i;
  assign shifted = word >> step;
  assign pop_o   = xfer_i && !have && !empty_i;

  for (genvar j = 0; j < 4; j++) begin : g_pix
    logic [3:0] v;
    always_comb begin
      unique case (bsel)
        BSEL_1:  v = {3'b0, word[j]};
        BSEL_2:  v = {2'b0, word[2*j +: 2]};
        default: v = word[4*j +: 4];
      endcase
      unique case (bsel)
        BSEL_1:  pix_o[j] = v[0];
        BSEL_2:  pix_o[j] = (v[1:0] > fc_i[1:0]);
        default: pix_o[j] = (v > fc_i);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur  <= '0;
      left <= '0;
      have <= 1'b0;
    end else if (flush_i) begin
      have <= 1'b0;
    end else if (xfer_i && ok_o) begin
      cur <= shifted;
      if (have) begin
        left <= left - 1'b1;
        if (left == 4'd1) have <= 1'b0;
      end else begin
        left <= per_m1;
        have <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/stn_timing.sv
module stn_timing #(
  parameter int unsigned WW     = 6,
  parameter int unsigned LW     = 10,
  parameter int unsigned HBLANK = 8,
  parameter int unsigned DIV    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic [WW-1:0] width_i,
  input  logic [LW-1:0] lines_i,
  output logic          xfer_o,
  output logic          line_end_o,
  output logic          first_line_o,
  output logic          frame_end_o,
  output logic [3:0]    fc_o
);
  localparam int unsigned XW = WW + 2;
  localparam int unsigned DW = $clog2(DIV + 1);
  localparam int unsigned BW = $clog2(HBLANK + 1);

  logic          act;
  logic [DW-1:0] div_cnt;
  logic [XW-1:0] xcnt, n_m1;
  logic [BW-1:0] bcnt;
  logic [LW-1:0] line;
  logic          div_last, blk_done, last_line;

  assign n_m1         = {width_i, 2'b11};
  assign div_last     = (div_cnt == DW'(DIV - 1));
  assign last_line    = (line == lines_i - 1'b1);
  assign xfer_o       = enable_i && act && (div_cnt == '0);
  assign line_end_o   = enable_i && act && div_last && (xcnt == n_m1);
  assign first_line_o = (line == '0);
  assign frame_end_o  = line_end_o && last_line;
  assign blk_done     = enable_i && !act && (bcnt == BW'(HBLANK - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act     <= 1'b0;
      div_cnt <= '0;
      xcnt    <= '0;
      bcnt    <= '0;
      line    <= '1;
      fc_o    <= '0;
    end else if (!enable_i) begin
      act     <= 1'b0;
      div_cnt <= '0;
      xcnt    <= '0;
      bcnt    <= '0;
      line    <= '1;
      fc_o    <= '0;
    end else if (act) begin
      div_cnt <= div_last ? '0 : div_cnt + 1'b1;
      if (div_last) begin
        if (xcnt == n_m1) begin
          act  <= 1'b0;
          xcnt <= '0;
          bcnt <= '0;
        end else begin
          xcnt <= xcnt + 1'b1;
        end
      end
      if (frame_end_o) fc_o <= fc_o + 1'b1;
    end else if (blk_done) begin
      act     <= 1'b1;
      div_cnt <= '0;
      xcnt    <= '0;
      line    <= (line >= lines_i - 1'b1) ? '0 : line + 1'b1;
    end else begin
      bcnt <= bcnt + 1'b1;
    end
  end
endmodule

// File: rtl/stn_refresh.sv
module stn_refresh #(
  parameter int unsigned AW     = 32,
  parameter int unsigned LW     = 10,
  parameter int unsigned FBW    = 16,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned HBLANK = 8,
  parameter int unsigned DIV    = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           enable_i,
  input  logic [AW-1:0]  base_addr_i,
  input  logic [5:0]     width_i,
  input  logic [1:0]     bpp_i,
  input  logic [LW-1:0]  lines_i,
  input  logic [FBW-1:0] fb_words_i,
  output logic           mem_req_o,
  output logic [AW-1:0]  mem_addr_o,
  input  logic           mem_ack_i,
  input  logic [31:0]    mem_rdata_i,
  output logic [3:0]     dd_o,
  output logic           pclk_o,
  output logic           lclk_o,
  output logic           frm_o,
  output logic           acb_o,
  output logic           underrun_o
);
  logic        xfer, line_end, first_line, frame_end, flush;
  logic        pop, ok, empty;
  logic [3:0]  fc, pix;
  logic [31:0] head;

  assign flush = !enable_i || frame_end;

  stn_timing #(.WW(6), .LW(LW), .HBLANK(HBLANK), .DIV(DIV)) u_timing (
    .clk_i, .rst_ni, .enable_i, .width_i, .lines_i,
    .xfer_o(xfer), .line_end_o(line_end), .first_line_o(first_line),
    .frame_end_o(frame_end), .fc_o(fc)
  );

  stn_fetch #(.AW(AW), .FBW(FBW), .DEPTH(DEPTH)) u_fetch (
    .clk_i, .rst_ni, .flush_i(flush), .base_i(base_addr_i), .fb_words_i,
    .mem_req_o, .mem_addr_o, .mem_ack_i, .mem_rdata_i,
    .pop_i(pop), .head_o(head), .empty_o(empty)
  );

  stn_unpack u_unpack (
    .clk_i, .rst_ni, .flush_i(flush), .xfer_i(xfer), .bpp_i, .fc_i(fc),
    .head_i(head), .empty_i(empty), .pop_o(pop), .ok_o(ok), .pix_o(pix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dd_o       <= '0;
      pclk_o     <= 1'b0;
      lclk_o     <= 1'b0;
      frm_o      <= 1'b0;
      acb_o      <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      pclk_o     <= xfer;
      dd_o       <= (xfer && ok) ? pix : 4'd0;
      lclk_o     <= line_end;
      frm_o      <= line_end && first_line;
      acb_o      <= acb_o ^ (line_end && first_line);
      underrun_o <= enable_i && (underrun_o || (xfer && !ok));
    end
  end
endmodule

// File: rtl/stn_refresh_chk.sv
module stn_refresh_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic mem_req_o,
  input logic mem_ack_i,
  input logic pclk_o,
  input logic lclk_o,
  input logic frm_o,
  input logic acb_o,
  input logic underrun_o
);
  p_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && $past(!enable_i)) |-> !(pclk_o || lclk_o || frm_o || underrun_o));

  p_noreq_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !mem_req_o);

  p_ack_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ack_i |-> mem_req_o);

  p_lclk_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lclk_o |=> !lclk_o);

  p_frm_lclk_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_o |-> lclk_o);

  p_acb_flip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_o |-> (acb_o != $past(acb_o)));

  p_acb_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_o |-> $stable(acb_o));

  p_underrun_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(enable_i) && $past(underrun_o)) |-> underrun_o);
endmodule

bind stn_refresh stn_refresh_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
  .mem_req_o(mem_req_o), .mem_ack_i(mem_ack_i), .pclk_o(pclk_o),
  .lclk_o(lclk_o), .frm_o(frm_o), .acb_o(acb_o), .underrun_o(underrun_o)
);

// File: tb/stn_refresh_test.sv
`timescale 1ns/1ps
module stn_refresh_test;
  localparam int HB = 8;
  localparam int DV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] base = '0;
  logic [5:0]  width = 6'd1;
  logic [1:0]  bpp = '0;
  logic [9:0]  lines = 10'd1;
  logic [15:0] fbw = 16'd1;
  logic        mem_req, mem_ack, mem_ok = 1'b1;
  logic [31:0] mem_addr, mem_rdata;
  logic [3:0]  dd;
  logic        pclk, lclk, frm, acb, underrun;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A3C_1E87;
  endfunction

  assign mem_ack   = mem_req && mem_ok;
  assign mem_rdata = mem_word(mem_addr);

  stn_refresh uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .base_addr_i(base),
    .width_i(width), .bpp_i(bpp), .lines_i(lines), .fb_words_i(fbw),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .dd_o(dd), .pclk_o(pclk), .lclk_o(lclk),
    .frm_o(frm), .acb_o(acb), .underrun_o(underrun)
  );

  task automatic chk(input bit c, input string req, input longint act, input longint exp);
    tests++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_dd(input logic [31:0] w, input int off,
                                        input logic [1:0] b, input logic [3:0] fc);
    logic [3:0] r;
    int nb;
    nb = (b == 2'd0) ? 1 : (b == 2'd1) ? 2 : 4;
    for (int j = 0; j < 4; j++) begin
      logic [3:0] v;
      v = 4'((w >> (off + j * nb)) & ((1 << nb) - 1));
      if (nb == 1)      r[j] = v[0];
      else if (nb == 2) r[j] = (v[1:0] > fc[1:0]);
      else              r[j] = (v > fc);
    end
    return r;
  endfunction

  // bench model state
  int m_widx, m_off, m_fidx, m_line, m_frame, m_xfers, frames_done;
  int gap, last_p, cyc;
  bit armed, restart, chk_dd, prev_acb;
  int n_pclk, n_lclk, n_req;

  always @(negedge clk) begin
    cyc++;
    if (armed) gap++;
    if (pclk) begin
      n_pclk++;
      if (armed) begin
        chk(gap == HB + 1, "R6 gap", gap, HB + 1);
        armed = 0;
      end else if (m_xfers > 0) begin
        chk(cyc - last_p == DV, "R3 spacing", cyc - last_p, DV);
      end
      last_p = cyc;
      if (chk_dd) begin
        logic [3:0] e;
        e = exp_dd(mem_word(base + 32'(m_widx * 4)), m_off, bpp, 4'(m_frame));
        chk(dd == e, "R4/R5 data", dd, e);
      end
      m_xfers++;
      m_off += (bpp == 2'd0) ? 4 : (bpp == 2'd1) ? 8 : 16;
      if (m_off >= 32) begin
        m_off = 0;
        m_widx = (m_widx + 1 == int'(fbw)) ? 0 : m_widx + 1;
      end
    end
    if (lclk) begin
      n_lclk++;
      chk(m_xfers == 4 * (int'(width) + 1), "R3 count", m_xfers, 4 * (int'(width) + 1));
      chk(frm == (m_line == 0), "R7 frame pulse", frm, m_line == 0);
      if (frm) begin
        chk(acb != prev_acb, "R8 bias", acb, !prev_acb);
        prev_acb = acb;
      end
      m_xfers = 0;
      gap = 0;
      armed = 1;
      if (m_line == int'(lines) - 1) begin
        m_line = 0; m_frame++; m_widx = 0; m_off = 0; m_fidx = 0;
        restart = 1; frames_done++;
      end else m_line++;
    end
    if (mem_req) n_req++;
    if (mem_req && mem_ack) begin
      logic [31:0] ea;
      ea = base + 32'(m_fidx * 4);
      if (restart) chk(mem_addr == ea, "R9 restart", mem_addr, ea);
      else         chk(mem_addr == ea, "R2 address", mem_addr, ea);
      restart = 0;
      m_fidx = (m_fidx + 1 == int'(fbw)) ? 0 : m_fidx + 1;
    end
  end

  task automatic run_cfg(input logic [31:0] b, input logic [5:0] w, input logic [1:0] p,
                         input logic [9:0] l, input logic [15:0] f, input int nfr);
    @(negedge clk);
    enable = 0;
    repeat (3) @(negedge clk);
    base = b; width = w; bpp = p; lines = l; fbw = f;
    m_widx = 0; m_off = 0; m_fidx = 0; m_line = 0; m_frame = 0; m_xfers = 0;
    frames_done = 0; armed = 0; restart = 1; chk_dd = 1; prev_acb = acb;
    enable = 1;
    while (frames_done < nfr) @(negedge clk);
    chk(underrun == 0, "R10 no false underrun", underrun, 0);
    enable = 0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({dd, pclk, lclk, frm, underrun, mem_req} == 0, "R1 reset",
        {dd, pclk, lclk, frm, underrun, mem_req}, 0);
    rst_n = 1;
    n_pclk = 0; n_lclk = 0; n_req = 0;
    repeat (30) @(negedge clk);
    chk(n_pclk + n_lclk + n_req == 0, "R1 idle", n_pclk + n_lclk + n_req, 0);

    // directed corners
    run_cfg(32'h0000_1000, 6'd1, 2'd0, 10'd3, 16'd1, 2);      // one-word buffer
    run_cfg(32'h0020_0040, 6'd2, 2'd0, 10'd3, 16'd5, 3);      // 48 px, line ends mid-word
    run_cfg(32'h0100_0000, 6'd63, 2'd2, 10'd2, 16'd32768, 2); // 1024 px, 128 KB
    run_cfg(32'h0000_0800, 6'd5, 2'd1, 10'd1, 16'd7, 6);      // single line, 2 bpp
    run_cfg(32'h0000_0400, 6'd3, 2'd2, 10'd2, 16'd9, 18);     // fc wraps at 4 bpp

    // random configurations
    for (int i = 0; i < 10; i++) begin
      logic [5:0] w;
      logic [1:0] p;
      logic [9:0] l;
      logic [15:0] f;
      w = 6'($urandom_range(1, 20));
      p = 2'($urandom_range(0, 2));
      l = 10'($urandom_range(1, 4));
      f = 16'($urandom_range(1, 60));
      run_cfg({$urandom} & 32'hFFFF_FFFC, w, p, l, f, 3);
    end

    // R10 underrun: stall memory mid-frame
    @(negedge clk);
    base = 32'h0000_2000; width = 6'd4; bpp = 2'd0; lines = 10'd3; fbw = 16'd40;
    m_widx = 0; m_off = 0; m_fidx = 0; m_line = 0; m_frame = 0; m_xfers = 0;
    frames_done = 0; armed = 0; restart = 1; chk_dd = 0; prev_acb = acb;
    enable = 1;
    repeat (50) @(negedge clk);
    mem_ok = 0;
    repeat (400) @(negedge clk);
    chk(underrun == 1, "R10 flag set", underrun, 1);
    while (!pclk) @(negedge clk);
    chk(dd == 4'd0, "R10 zero data", dd, 0);
    mem_ok = 1;
    repeat (20) @(negedge clk);
    chk(underrun == 1, "R10 sticky", underrun, 1);
    enable = 0;
    repeat (2) @(negedge clk);
    chk(underrun == 0, "R10 clear", underrun, 0);
    n_pclk = 0; n_lclk = 0; n_req = 0;
    repeat (20) @(negedge clk);
    chk(n_pclk + n_lclk + n_req == 0, "R1 disabled", n_pclk + n_lclk + n_req, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule